// File: doc/BRIEF.md
# Multi-Channel Interrupt Aggregator

This block merges the interrupt requests of a bank of serial channels into one host interrupt line. Channels come in groups of sixteen. Each group has a per-channel mask and its own enable bit, and a card-wide enable sits above every group. The requests arrive as level signals from the channel logic. The status view shows them as they are, and this block does not latch them.

A channel counts as pending when its request is high and its mask bit is clear. A set mask bit blocks the channel, and reset sets every mask bit, so software must unmask the channels it wants. A group adds its pending channels to the output only while its group enable is set. The output register goes high only when the card enable is also set. When the configured port count is sixteen or more, a second group exists, and the output is the OR of both gated groups. A flat register port with a write strobe gives access to the status, mask and enable registers. Reads are combinational.

Top module: `chan_irq_agg`

## Requirements
- R1: After reset, `irq_o` is 0. Both mask registers read 0x0000FFFF. Both group enable registers and the card enable register read 0.
- R2: Offset 0x004 of a group reads that group's request inputs in bits 15:0, in the same cycle as they change. Group 0 uses `chan_req_i[15:0]` and group 1 uses `chan_req_i[31:16]`. Bits 31:16 read 0.
- R3: Offset 0x008 of a group is its mask. A write stores bits 15:0 and discards bits 31:16, which read 0.
- R4: Channel n of a group is pending only when its request bit n is 1 and its mask bit n is 0. A channel whose mask bit is 1 never raises `irq_o`.
- R5: Bit 20 at offset 0x100 of a group is the group enable. While it is 0, the group adds nothing to the output. The other bits of that register are not stored and read 0.
- R6: Bit 0 of the card register at address 0x0F0 is the card enable. While it is 0, `irq_o` stays 0 whatever the groups hold.
- R7: Group g sits at address base g×0x1000. When `NUM_PORTS` ≥ 16, group 1 exists, and `irq_o` is the OR of both gated groups.
- R8: `irq_o` is a registered level. It reflects the requests, masks and enables one clock edge after they change, and it stays high as long as a gated pending channel exists.
- R9: Writes to the status offset have no effect. Addresses outside the mapped registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_req_i | input | 2×CHANS | Level request per channel, group 0 in the low half |
| reg_addr_i | input | ADDR_W | Byte address of the register port |
| reg_we_i | input | 1 | Write strobe, applied on the rising edge |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Registered host interrupt level |

## Verification
Directed steps enable one gate at a time. A request with a clear mask but the card enable off must stay silent. Masking exactly the requested bits must silence a group, and moving one mask bit must bring the output back. Pending channels confined to group 1 separate the OR of the two groups from the path through group 0 alone. Request edges checked before and after the next clock edge pin the single register stage. A pseudo-random phase then varies requests, masks and enables every cycle against a reference model. This exposes wrong mask polarity, missing gates and address aliasing that the directed steps do not reach.

// File: rtl/chan_irq_agg_pkg.sv
package chan_irq_agg_pkg;
   localparam int GRP_SPAN_LOG2 = 12;
   localparam int MAX_GROUPS    = 2;
   localparam logic [GRP_SPAN_LOG2-1:0] OFS_STATUS = 12'h004;
   localparam logic [GRP_SPAN_LOG2-1:0] OFS_MASK   = 12'h008;
   localparam logic [GRP_SPAN_LOG2-1:0] OFS_GEN    = 12'h100;
   localparam logic [GRP_SPAN_LOG2-1:0] OFS_CARD   = 12'h0F0;
   localparam int CARD_EN_BIT = 0;

   function automatic int group_count(input int ports, input int chans);
      return (ports >= chans) ? 2 : 1;
   endfunction
endpackage

// File: rtl/chan_irq_agg_group.sv
module chan_irq_agg_group #(
   parameter int CHANS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CHANS-1:0] req_i,
   input  logic             mask_we_i,
   input  logic [CHANS-1:0] mask_wdata_i,
   input  logic             gen_we_i,
   input  logic             gen_wdata_i,
   output logic [CHANS-1:0] mask_o,
   output logic             gen_o,
   output logic             pend_o
);
   logic [CHANS-1:0] mask_q;
   logic             gen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '1;
         gen_q  <= 1'b0;
      end else begin
         if (mask_we_i) mask_q <= mask_wdata_i;
         if (gen_we_i)  gen_q  <= gen_wdata_i;
      end
   end

   assign mask_o = mask_q;
   assign gen_o  = gen_q;
   assign pend_o = gen_q & (|(req_i & ~mask_q));
endmodule

// File: rtl/chan_irq_agg_decode.sv
module chan_irq_agg_decode
   import chan_irq_agg_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int NUM_GROUPS = 2
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              grp_o,
   output logic              hit_status_o,
   output logic              hit_mask_o,
   output logic              hit_gen_o,
   output logic              hit_card_o
);
   logic                     upper_zero;
   logic                     grp_ok;
   logic [GRP_SPAN_LOG2-1:0] ofs;

   generate
      if (ADDR_W > GRP_SPAN_LOG2 + 1) begin : g_upper
         assign upper_zero = ~|addr_i[ADDR_W-1:GRP_SPAN_LOG2+1];
      end else begin : g_no_upper
         assign upper_zero = 1'b1;
      end
   endgenerate

   assign ofs    = addr_i[GRP_SPAN_LOG2-1:0];
   assign grp_o  = addr_i[GRP_SPAN_LOG2];
   assign grp_ok = upper_zero & ((NUM_GROUPS > 1) | ~grp_o);

   assign hit_status_o = grp_ok & (ofs == OFS_STATUS);
   assign hit_mask_o   = grp_ok & (ofs == OFS_MASK);
   assign hit_gen_o    = grp_ok & (ofs == OFS_GEN);
   assign hit_card_o   = upper_zero & ~grp_o & (ofs == OFS_CARD);
endmodule

// File: rtl/chan_irq_agg.sv
module chan_irq_agg
   import chan_irq_agg_pkg::*;
#(
   parameter int CHANS     = 16,
   parameter int NUM_PORTS = 32,
   parameter int ADDR_W    = 13,
   parameter int DATA_W    = 32,
   parameter int GEN_BIT   = 20
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [MAX_GROUPS*CHANS-1:0] chan_req_i,
   input  logic [ADDR_W-1:0]           reg_addr_i,
   input  logic                        reg_we_i,
   input  logic [DATA_W-1:0]           reg_wdata_i,
   output logic [DATA_W-1:0]           reg_rdata_o,
   output logic                        irq_o
);
   localparam int NUM_GROUPS = group_count(NUM_PORTS, CHANS);

   generate
      if (CHANS > DATA_W || GEN_BIT >= DATA_W) begin : g_bad_width
         $error("chan_irq_agg: CHANS and GEN_BIT must fit in DATA_W");
      end
      if (NUM_PORTS > MAX_GROUPS * CHANS || NUM_PORTS < 1) begin : g_bad_ports
         $error("chan_irq_agg: NUM_PORTS out of range");
      end
      if (ADDR_W < GRP_SPAN_LOG2 + 1) begin : g_bad_addr
         $error("chan_irq_agg: ADDR_W too small for two groups");
      end
   endgenerate

   logic                        grp_sel, hit_status, hit_mask, hit_gen, hit_card;
   logic [CHANS-1:0]            req_g  [MAX_GROUPS];
   logic [CHANS-1:0]            mask_g [MAX_GROUPS];
   logic [MAX_GROUPS*CHANS-1:0] grp_mask;
   logic [MAX_GROUPS-1:0]       grp_en;
   logic [MAX_GROUPS-1:0]       grp_pend;
   logic                        card_en_q;
   logic                        irq_q;
   logic                        unused_wdata;

   assign unused_wdata = ^reg_wdata_i;

   chan_irq_agg_decode #(.ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS)) u_dec (
      .addr_i      (reg_addr_i),
      .grp_o       (grp_sel),
      .hit_status_o(hit_status),
      .hit_mask_o  (hit_mask),
      .hit_gen_o   (hit_gen),
      .hit_card_o  (hit_card)
   );

   generate
      for (genvar g = 0; g < MAX_GROUPS; g++) begin : g_grp
         assign req_g[g] = chan_req_i[g*CHANS +: CHANS];
         assign grp_mask[g*CHANS +: CHANS] = mask_g[g];
         if (g < NUM_GROUPS) begin : g_live
            chan_irq_agg_group #(.CHANS(CHANS)) u_grp (
               .clk         (clk),
               .rst_n       (rst_n),
               .req_i       (req_g[g]),
               .mask_we_i   (reg_we_i & hit_mask & (grp_sel == g[0])),
               .mask_wdata_i(reg_wdata_i[CHANS-1:0]),
               .gen_we_i    (reg_we_i & hit_gen & (grp_sel == g[0])),
               .gen_wdata_i (reg_wdata_i[GEN_BIT]),
               .mask_o      (mask_g[g]),
               .gen_o       (grp_en[g]),
               .pend_o      (grp_pend[g])
            );
         end else begin : g_absent
            assign mask_g[g]   = '1;
            assign grp_en[g]   = 1'b0;
            assign grp_pend[g] = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         card_en_q <= 1'b0;
         irq_q     <= 1'b0;
      end else begin
         if (reg_we_i && hit_card) card_en_q <= reg_wdata_i[CARD_EN_BIT];
         irq_q <= card_en_q & (|grp_pend);
      end
   end

   always_comb begin
      reg_rdata_o = '0;
      if (hit_status)    reg_rdata_o[CHANS-1:0]   = req_g[grp_sel];
      else if (hit_mask) reg_rdata_o[CHANS-1:0]   = mask_g[grp_sel];
      else if (hit_gen)  reg_rdata_o[GEN_BIT]     = grp_en[grp_sel];
      else if (hit_card) reg_rdata_o[CARD_EN_BIT] = card_en_q;
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/chan_irq_agg_chk.sv
module chan_irq_agg_chk #(
   parameter int CHANS  = 16,
   parameter int ADDR_W = 13,
   parameter int DATA_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic [2*CHANS-1:0]  chan_req_i,
   input logic [ADDR_W-1:0]   reg_addr_i,
   input logic [DATA_W-1:0]   reg_rdata_o,
   input logic [2*CHANS-1:0]  grp_mask,
   input logic [1:0]          grp_en,
   input logic                card_en_q,
   input logic                irq_o
);
   logic g0_live, g1_live;
   assign g0_live = grp_en[0] & (|(chan_req_i[CHANS-1:0] & ~grp_mask[CHANS-1:0]));
   assign g1_live = grp_en[1] & (|(chan_req_i[2*CHANS-1:CHANS] & ~grp_mask[2*CHANS-1:CHANS]));

   AST_CARD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !card_en_q |=> !irq_o);                                          // R6
   AST_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      !(g0_live || g1_live) |=> !irq_o);                               // R4
   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (card_en_q && (g0_live || g1_live)) |=> irq_o);                  // R8
   AST_GROUP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_en == 2'b00) |=> !irq_o);                                   // R5
   AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_i == ADDR_W'(12'h004)) |-> (reg_rdata_o == DATA_W'(chan_req_i[CHANS-1:0]))); // R2
endmodule

bind chan_irq_agg chan_irq_agg_chk #(.CHANS(CHANS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .chan_req_i (chan_req_i),
   .reg_addr_i (reg_addr_i),
   .reg_rdata_o(reg_rdata_o),
   .grp_mask   (grp_mask),
   .grp_en     (grp_en),
   .card_en_q  (card_en_q),
   .irq_o      (irq_o)
);

// File: tb/chan_irq_agg_tb.sv
module chan_irq_agg_tb;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] req = '0;
   logic [12:0] addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;

   logic [15:0] m_mask [2];
   logic [1:0]  m_gen;
   logic        m_cen;
   logic        m_irq;

   always #(PERIOD/2) clk = ~clk;

   chan_irq_agg u_dut (
      .clk(clk), .rst_n(rst_n), .chan_req_i(req), .reg_addr_i(addr),
      .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
   );

   // reference model
   always @(posedge clk) begin
      if (!rst_n) begin
         m_mask[0] <= 16'hFFFF; m_mask[1] <= 16'hFFFF;
         m_gen <= 2'b00; m_cen <= 1'b0; m_irq <= 1'b0;
      end else begin
         m_irq <= m_cen && ((m_gen[0] && ((req[15:0] & ~m_mask[0]) != 0)) ||
                            (m_gen[1] && ((req[31:16] & ~m_mask[1]) != 0)));
         if (we) begin
            case (addr)
               13'h0008: m_mask[0] <= wdata[15:0];
               13'h1008: m_mask[1] <= wdata[15:0];
               13'h0100: m_gen[0]  <= wdata[20];
               13'h1100: m_gen[1]  <= wdata[20];
               13'h00F0: m_cen     <= wdata[0];
               default: ;
            endcase
         end
      end
   end

   function automatic logic [31:0] exp_read(input logic [12:0] a);
      case (a)
         13'h0004: return {16'h0, req[15:0]};
         13'h1004: return {16'h0, req[31:16]};
         13'h0008: return {16'h0, m_mask[0]};
         13'h1008: return {16'h0, m_mask[1]};
         13'h0100: return 32'(m_gen[0]) << 20;
         13'h1100: return 32'(m_gen[1]) << 20;
         13'h00F0: return 32'(m_cen);
         default:  return 32'h0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // per-cycle comparison against the model (R8 timing, R2 live reads)
   always @(negedge clk) begin
      if (rst_n) begin
         #2;
         chk("R8 irq vs model", 32'(irq), 32'(m_irq));
         chk("R2 rdata vs model", rdata, exp_read(addr));
      end
   end

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [12:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [12:0] a, input logic [31:0] exp);
      @(negedge clk);
      addr = a;
      #3;
      chk(tag, rdata, exp);
   endtask

   initial begin
      #(PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] lfsr;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      #3;
      chk("R1 irq after reset", 32'(irq), 32'h0);
      rd("R1 mask0 reset", 13'h0008, 32'h0000FFFF);
      rd("R1 mask1 reset", 13'h1008, 32'h0000FFFF);
      rd("R1 gen0 reset", 13'h0100, 32'h0);
      rd("R1 gen1 reset", 13'h1100, 32'h0);
      rd("R1 card reset", 13'h00F0, 32'h0);

      @(negedge clk); req = 32'h0000_00A5;
      rd("R2 status0", 13'h0004, 32'h000000A5);
      rd("R2 status1 idle", 13'h1004, 32'h0);
      @(negedge clk); addr = 13'h1004; req = 32'h3C00_00A5; #3;
      chk("R2 status1 same cycle", rdata, 32'h00003C00);

      wr(13'h0004, 32'hFFFF_FFFF);
      rd("R9 status write ignored", 13'h0004, 32'h000000A5);
      rd("R9 unmapped 0x00C", 13'h000C, 32'h0);
      rd("R9 unmapped 0x1F0", 13'h01F0, 32'h0);
      rd("R9 card alias in group1", 13'h10F0, 32'h0);

      wr(13'h0008, 32'hFFFF_1234);
      rd("R3 mask upper dropped", 13'h0008, 32'h00001234);

      wr(13'h0008, 32'h0);
      wr(13'h0100, 32'h0010_0000);
      tick(3); #3;
      chk("R6 card off blocks", 32'(irq), 32'h0);
      wr(13'h00F0, 32'h1);
      tick(1); #3;
      chk("R6 card on passes", 32'(irq), 32'h1);

      wr(13'h0008, 32'h0000_00A5);
      tick(1); #3;
      chk("R4 all requested masked", 32'(irq), 32'h0);
      wr(13'h0008, 32'h0000_00A4);
      tick(1); #3;
      chk("R4 bit0 unmasked", 32'(irq), 32'h1);

      wr(13'h0100, 32'hFFEF_FFFF);
      tick(1); #3;
      chk("R5 group off", 32'(irq), 32'h0);
      rd("R5 gen other bits not stored", 13'h0100, 32'h0);

      wr(13'h1008, 32'h0);
      wr(13'h1100, 32'h0010_0000);
      tick(1); #3;
      chk("R7 group1 alone drives", 32'(irq), 32'h1);
      rd("R7 gen1 readback", 13'h1100, 32'h00100000);

      @(negedge clk); req = 32'h0000_00A5; #2;
      chk("R8 holds until edge", 32'(irq), 32'h1);
      @(negedge clk); #2;
      chk("R8 drops after edge", 32'(irq), 32'h0);

      lfsr = 32'hACE1_2468;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         req = lfsr ^ {lfsr[15:0], lfsr[31:16]};
         we = lfsr[3];
         wdata = {lfsr[7:0], lfsr[31:8]};
         case (lfsr[6:4])
            3'd0: addr = 13'h0008;
            3'd1: addr = 13'h1008;
            3'd2: addr = 13'h0100;
            3'd3: addr = 13'h1100;
            3'd4: addr = 13'h00F0;
            3'd5: addr = 13'h0004;
            3'd6: addr = 13'h1004;
            default: addr = {lfsr[12:9], 9'h0F0};
         endcase
      end
      @(negedge clk); we = 1'b0;
      tick(2);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule